// File: doc/BRIEF.md
# Dual-Issue Pairing Hazard Checker

This block sits at the issue point of a two-wide, in-order superscalar pipeline. Every cycle it looks at the two decoded instructions presented to it: the older one (the "old" slot) and the younger one (the "young" slot). It decides whether the two can leave together, which of the two execution lanes each one takes, and whether the younger one has to be held back.

Lane 0 carries an ALU and the only multiplier. Lane 1 carries an ALU, the only shifter and the only load/store unit. Two hazards inside the pair make the younger instruction wait:
- a structural clash over a single-copy unit or over a lane;
- a read by the younger instruction of a register that the older one writes.

A held younger instruction is re-presented by the front end as the old slot of the next pair, so program order is kept. A global stall input suppresses all issue. The decision is registered, so the outputs describe the pair presented one cycle earlier.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While reset is asserted, and until the first capture after the synchronised release, every output is 0.
- R2: The outputs are registered. A pair presented before a rising edge is reported after that edge, one cycle later. A valid old instruction with no stall always has iss_old_o=1.
- R3: Unit class codes are ALU=0, MUL=1, SHF=2, LSU=3. An issuing old instruction of class ALU or MUL takes lane 0 (lane_old_o=0). One of class SHF or LSU takes lane 1 (lane_old_o=1).
- R4: When the old instruction takes lane 1, a valid young instruction does not issue, and hold_young_o=1.
- R5: A valid young instruction of class MUL behind a valid old instruction does not issue, and hold_young_o=1. This covers the case where both need the multiplier.
- R6: The young instruction issues when all of these hold: the old instruction is in lane 0, the young class is not MUL, and there is no dependence. It then reports iss_young_o=1, lane_young_o=1 and hold_young_o=0.
- R7: The young instruction has a dependence, and is held (iss_young_o=0, hold_young_o=1), when the old instruction has write enable set and a destination that is not register 0, and either young source register equals that destination.
- R8: A destination of register 0, or a cleared write enable, never creates a dependence.
- R9: When the old slot is invalid, a valid young instruction issues as the leading instruction. Its lane follows the R3 mapping for its own class, and hold_young_o=0.
- R10: With stall_i=1, the next outputs are iss_old_o=0, iss_young_o=0 and hold_young_o=0, and both lanes read 0.
- R11: An invalid young slot gives iss_young_o=0 and hold_young_o=0. A lane output whose instruction does not issue reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Global stall; blocks all issue |
| old_vld_i | input | 1 | Old slot valid |
| old_cls_i | input | 2 | Old unit class |
| old_dst_i | input | 5 | Old destination register |
| old_wen_i | input | 1 | Old write enable |
| old_src0_i | input | 5 | Old first source register |
| old_src1_i | input | 5 | Old second source register |
| yng_vld_i | input | 1 | Young slot valid |
| yng_cls_i | input | 2 | Young unit class |
| yng_dst_i | input | 5 | Young destination register |
| yng_wen_i | input | 1 | Young write enable |
| yng_src0_i | input | 5 | Young first source register |
| yng_src1_i | input | 5 | Young second source register |
| iss_old_o | output | 1 | Old instruction issues |
| iss_young_o | output | 1 | Young instruction issues |
| lane_old_o | output | 1 | Lane taken by the old instruction |
| lane_young_o | output | 1 | Lane taken by the young instruction |
| hold_young_o | output | 1 | Young instruction held for the next pair |

## Verification
The decision is registered, so a wrong lane map or a wrong dependence compare shows one cycle after the pair is presented. It appears either as both instructions sharing a lane, or as a young instruction that issues when it should be held. Each scenario therefore drives one pair and samples just after the next rising edge. A missed stall or a hold flag that sticks shows in the same cycle on iss and hold together. Register-0 writes, a cleared write enable and an empty old slot are driven on purpose to catch a compare that is too eager.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int unsigned REG_W = 5;
  localparam int unsigned NSRC  = 2;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_MUL = 2'd1,
    CLS_SHF = 2'd2,
    CLS_LSU = 2'd3
  } unit_cls_e;
endpackage

// File: rtl/dip_rst_sync.sv
module dip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/dip_lane_map.sv
module dip_lane_map
  import dip_pkg::*;
(
  input  logic [1:0] cls,
  output logic       need_l0,
  output logic       need_l1
);
  always_comb begin
    need_l0 = (cls == CLS_MUL);
    need_l1 = (cls == CLS_SHF) || (cls == CLS_LSU);
  end
endmodule

// File: rtl/dip_raw_detect.sv
module dip_raw_detect
  import dip_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned NS = NSRC
) (
  input  logic                 wen,
  input  logic [RW-1:0]        dst,
  input  logic [NS-1:0][RW-1:0] srcs,
  output logic                 hit
);
  logic [NS-1:0] match;
  logic          dst_live;

  assign dst_live = wen && (dst != '0);

  for (genvar g = 0; g < NS; g++) begin : g_src
    assign match[g] = dst_live && (srcs[g] == dst);
  end

  assign hit = |match;
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dip_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          old_vld_i,
  input  logic [1:0]    old_cls_i,
  input  logic [RW-1:0] old_dst_i,
  input  logic          old_wen_i,
  input  logic [RW-1:0] old_src0_i,
  input  logic [RW-1:0] old_src1_i,
  input  logic          yng_vld_i,
  input  logic [1:0]    yng_cls_i,
  input  logic [RW-1:0] yng_dst_i,
  input  logic          yng_wen_i,
  input  logic [RW-1:0] yng_src0_i,
  input  logic [RW-1:0] yng_src1_i,
  output logic          iss_old_o,
  output logic          iss_young_o,
  output logic          lane_old_o,
  output logic          lane_young_o,
  output logic          hold_young_o
);
  logic rst_s;
  logic old_l0, old_l1, yng_l0, yng_l1;
  logic raw_hit;
  logic [NSRC-1:0][RW-1:0] yng_srcs;

  logic n_iss_old, n_iss_yng, n_lane_old, n_lane_yng, n_hold;
  logic q_iss_old, q_iss_yng, q_lane_old, q_lane_yng, q_hold;
  logic cap_en;

  dip_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  dip_lane_map u_map_old (.cls(old_cls_i), .need_l0(old_l0), .need_l1(old_l1));
  dip_lane_map u_map_yng (.cls(yng_cls_i), .need_l0(yng_l0), .need_l1(yng_l1));

  assign yng_srcs = {yng_src1_i, yng_src0_i};

  dip_raw_detect #(.RW(RW), .NS(NSRC)) u_raw (
    .wen(old_wen_i), .dst(old_dst_i), .srcs(yng_srcs), .hit(raw_hit)
  );

  always_comb begin
    n_iss_old  = 1'b0;
    n_iss_yng  = 1'b0;
    n_lane_old = 1'b0;
    n_lane_yng = 1'b0;
    n_hold     = 1'b0;
    if (!stall_i) begin
      if (old_vld_i) begin
        n_iss_old  = 1'b1;
        n_lane_old = old_l1;
        if (yng_vld_i) begin
          if (old_l1 || yng_l0 || raw_hit) begin
            n_hold = 1'b1;
          end else begin
            n_iss_yng  = 1'b1;
            n_lane_yng = 1'b1;
          end
        end
      end else if (yng_vld_i) begin
        n_iss_yng  = 1'b1;
        n_lane_yng = yng_l1;
      end
    end
  end

  assign cap_en = 1'b1;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      q_iss_old  <= 1'b0;
      q_iss_yng  <= 1'b0;
      q_lane_old <= 1'b0;
      q_lane_yng <= 1'b0;
      q_hold     <= 1'b0;
    end else if (cap_en) begin
      q_iss_old  <= n_iss_old;
      q_iss_yng  <= n_iss_yng;
      q_lane_old <= n_lane_old;
      q_lane_yng <= n_lane_yng;
      q_hold     <= n_hold;
    end
  end

  assign iss_old_o    = q_iss_old;
  assign iss_young_o  = q_iss_yng;
  assign lane_old_o   = q_lane_old;
  assign lane_young_o = q_lane_yng;
  assign hold_young_o = q_hold;

  // R6: two issued instructions never share a lane
  p_no_lane_clash_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (iss_old_o && iss_young_o) |-> (lane_old_o != lane_young_o));

  // R4: a held young instruction implies the old one issued and young did not
  p_hold_excl_r4: assert property (@(posedge clk) disable iff (!rst_s)
    hold_young_o |-> (iss_old_o && !iss_young_o));

  // R10: stall suppresses all issue on the next cycle
  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_s)
    $past(stall_i) |-> (!iss_old_o && !iss_young_o && !hold_young_o));

  // R7: a detected dependence with a valid old slot blocks the young issue
  p_raw_blocks_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $past(raw_hit && old_vld_i) |-> !iss_young_o);

  // R5: a multiplier young instruction behind a valid old one never issues
  p_mul_pair_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $past(old_vld_i && yng_l0) |-> !iss_young_o);
endmodule

// File: tb/dual_issue_pair_check_test.sv
`timescale 1ns/1ps
module dual_issue_pair_check_test;
  logic clk = 1'b0;
  logic rst_n;
  logic stall_i;
  logic old_vld_i, old_wen_i, yng_vld_i, yng_wen_i;
  logic [1:0] old_cls_i, yng_cls_i;
  logic [4:0] old_dst_i, old_src0_i, old_src1_i;
  logic [4:0] yng_dst_i, yng_src0_i, yng_src1_i;
  logic iss_old_o, iss_young_o, lane_old_o, lane_young_o, hold_young_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [1:0] ALU = 2'd0, MUL = 2'd1, SHF = 2'd2, LSU = 2'd3;

  always #2.5 clk = ~clk;

  dual_issue_pair_check uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .old_vld_i(old_vld_i), .old_cls_i(old_cls_i), .old_dst_i(old_dst_i),
    .old_wen_i(old_wen_i), .old_src0_i(old_src0_i), .old_src1_i(old_src1_i),
    .yng_vld_i(yng_vld_i), .yng_cls_i(yng_cls_i), .yng_dst_i(yng_dst_i),
    .yng_wen_i(yng_wen_i), .yng_src0_i(yng_src0_i), .yng_src1_i(yng_src1_i),
    .iss_old_o(iss_old_o), .iss_young_o(iss_young_o), .lane_old_o(lane_old_o),
    .lane_young_o(lane_young_o), .hold_young_o(hold_young_o)
  );

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {iss_old_o, iss_young_o, lane_old_o, lane_young_o, hold_young_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {iss_old,iss_yng,lane_old,lane_yng,hold} actual=%b expected=%b",
               req, act, exp);
    end
  endtask

  task automatic drive(input logic st,
                       input logic ov, input logic [1:0] oc, input logic [4:0] od,
                       input logic ow, input logic [4:0] os0, input logic [4:0] os1,
                       input logic yv, input logic [1:0] yc,
                       input logic [4:0] ys0, input logic [4:0] ys1);
    @(negedge clk);
    stall_i = st;
    old_vld_i = ov; old_cls_i = oc; old_dst_i = od; old_wen_i = ow;
    old_src0_i = os0; old_src1_i = os1;
    yng_vld_i = yv; yng_cls_i = yc; yng_dst_i = 5'd9; yng_wen_i = 1'b1;
    yng_src0_i = ys0; yng_src1_i = ys1;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(0, 1, ALU, 5'd1, 1, 5'd2, 5'd3, 1, ALU, 5'd4, 5'd5);
    check("R1 reset", 5'b00000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 sync release", 5'b00000);
    @(posedge clk); #1;
  endtask

  task automatic t_lane_old;
    drive(0, 1, ALU, 5'd1, 1, 5'd2, 5'd3, 0, ALU, 5'd0, 5'd0);
    check("R2 R3 old ALU lane0", 5'b10000);
    drive(0, 1, MUL, 5'd1, 1, 5'd2, 5'd3, 0, ALU, 5'd0, 5'd0);
    check("R3 old MUL lane0", 5'b10000);
    drive(0, 1, SHF, 5'd1, 1, 5'd2, 5'd3, 0, ALU, 5'd0, 5'd0);
    check("R3 R11 old SHF lane1", 5'b10100);
  endtask

  task automatic t_upper_lane1;
    drive(0, 1, LSU, 5'd1, 1, 5'd2, 5'd3, 1, ALU, 5'd4, 5'd5);
    check("R4 old LSU holds young", 5'b10101);
  endtask

  task automatic t_mul;
    drive(0, 1, MUL, 5'd1, 1, 5'd2, 5'd3, 1, MUL, 5'd4, 5'd5);
    check("R5 MUL pair", 5'b10001);
    drive(0, 1, ALU, 5'd1, 1, 5'd2, 5'd3, 1, MUL, 5'd4, 5'd5);
    check("R5 young MUL behind ALU", 5'b10001);
  endtask

  task automatic t_pair_ok;
    drive(0, 1, ALU, 5'd1, 1, 5'd2, 5'd3, 1, LSU, 5'd4, 5'd5);
    check("R6 ALU+LSU dual issue", 5'b11010);
    drive(0, 1, MUL, 5'd7, 1, 5'd2, 5'd3, 1, SHF, 5'd4, 5'd5);
    check("R6 MUL+SHF dual issue", 5'b11010);
  endtask

  task automatic t_raw;
    drive(0, 1, ALU, 5'd6, 1, 5'd2, 5'd3, 1, ALU, 5'd6, 5'd5);
    check("R7 RAW src0", 5'b10001);
    drive(0, 1, ALU, 5'd6, 1, 5'd2, 5'd3, 1, ALU, 5'd4, 5'd6);
    check("R7 RAW src1", 5'b10001);
  endtask

  task automatic t_no_raw;
    drive(0, 1, ALU, 5'd0, 1, 5'd2, 5'd3, 1, ALU, 5'd0, 5'd0);
    check("R8 dst zero no dep", 5'b11010);
    drive(0, 1, ALU, 5'd6, 0, 5'd2, 5'd3, 1, ALU, 5'd6, 5'd6);
    check("R8 wen clear no dep", 5'b11010);
  endtask

  task automatic t_old_empty;
    drive(0, 0, ALU, 5'd6, 1, 5'd2, 5'd3, 1, MUL, 5'd6, 5'd6);
    check("R9 young MUL leads lane0", 5'b01000);
    drive(0, 0, ALU, 5'd6, 1, 5'd2, 5'd3, 1, LSU, 5'd4, 5'd5);
    check("R9 young LSU leads lane1", 5'b01010);
  endtask

  task automatic t_stall;
    drive(1, 1, SHF, 5'd1, 1, 5'd2, 5'd3, 1, ALU, 5'd1, 5'd5);
    check("R10 stall", 5'b00000);
    drive(0, 0, ALU, 5'd1, 1, 5'd2, 5'd3, 0, ALU, 5'd1, 5'd5);
    check("R11 nothing valid", 5'b00000);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    stall_i = 1'b0;
    old_vld_i = 0; old_cls_i = 0; old_dst_i = 0; old_wen_i = 0;
    old_src0_i = 0; old_src1_i = 0;
    yng_vld_i = 0; yng_cls_i = 0; yng_dst_i = 0; yng_wen_i = 0;
    yng_src0_i = 0; yng_src1_i = 0;
    t_reset();
    t_lane_old();
    t_upper_lane1();
    t_mul();
    t_pair_ok();
    t_raw();
    t_no_raw();
    t_old_empty();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule